// File: doc/BRIEF.md
# Posted-Write AHB-to-APB Bridge

This block connects a single-master AHB-Lite style bus on a fast clock to an APB peripheral bus. The APB side is paced by a clock-enable tick that fires once every N fast-clock cycles, where N is a programmable ratio. No real second clock exists. A write marked bufferable is parked in a one-entry posted-write store. The AHB master sees that write complete at once, and the store drains to APB later.

Non-bufferable writes and all reads keep the AHB data phase stalled until their own APB transfer has finished. A read only starts once the posted store is empty, so reading any register back forces every earlier posted write to land first. The drain delay is shown on the `busy_o` output rather than hidden. A peripheral status-clear written as a posted write therefore takes effect a measurable number of cycles after the AHB side has moved on.

Top module: `ahb_apb_post_bridge`

## Requirements
- R1: After reset, `hready_o` is 1, `hresp_o` is 0, `psel_o`, `penable_o`, `busy_o` and `post_err_o` are 0.
- R2: A write whose `hprot_buf_i` is 1, arriving while the posted store is empty, completes in its first data-phase cycle (`hready_o`=1, `hresp_o`=0). `busy_o` is 1 from the next cycle until that write has finished on APB.
- R3: A write whose `hprot_buf_i` is 0 keeps `hready_o` at 0 until its APB access completes. With a zero-wait peripheral and the bridge idle at the address phase, its data phase lasts 3N+1 cycles. `busy_o` stays 0.
- R4: A read never completes while a posted write is pending. The posted write appears on APB before the read, and the read returns the `prdata_i` value sampled in the completing access cycle.
- R5: A bufferable write that arrives while the posted store is full is stalled (`hready_o`=0) until the store drains. It is then accepted, and the two writes reach APB in arrival order.
- R6: Each APB transfer spends one tick period in SETUP (`psel_o`=1, `penable_o`=0), then enters ACCESS (`penable_o`=1). `pready_i` is sampled only on ticks, and ACCESS is extended by one tick period for every tick on which it is 0.
- R7: The tick fires one cycle in every N. N is taken from `div_i` while the bridge is idle, with 0 treated as 1. Idle means no posted write pending, sequencer idle and no AHB data phase. A posted write issued from idle to a zero-wait peripheral holds `busy_o` high for exactly 3N cycles when N≥2. A non-bufferable read issued from idle with N=1 has a 4-cycle data phase.
- R8: `pslverr_i` on a non-posted transfer gives a two-cycle ERROR response: `hresp_o`=1 with `hready_o`=0, then `hresp_o`=1 with `hready_o`=1.
- R9: `pslverr_i` on a posted write leaves the AHB response OKAY and sets `post_err_o`, which stays 1 until reset.
- R10: A change of `div_i` while the bridge is not idle has no effect on the transfer in flight.
- R11: `paddr_o`, `pwrite_o`, `pwdata_o` and `pstrb_o` carry the transfer's address, direction, write data and byte strobes. They stay stable through SETUP and ACCESS, and `pstrb_o` is 0 for reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| div_i | input | DIV_W | APB tick ratio N, sampled while idle |
| hsel_i | input | 1 | Bridge selected |
| htrans_i | input | 2 | Transfer type, bit 1 marks an active transfer |
| hwrite_i | input | 1 | 1 for write |
| hprot_buf_i | input | 1 | Bufferable protection bit |
| haddr_i | input | AW | Transfer address |
| hwstrb_i | input | DW/8 | Write byte strobes, data phase |
| hwdata_i | input | DW | Write data, data phase |
| hrdata_o | output | DW | Read data |
| hready_o | output | 1 | Transfer done / address accepted |
| hresp_o | output | 1 | 1 for ERROR response |
| psel_o | output | 1 | APB select |
| penable_o | output | 1 | APB access phase |
| pwrite_o | output | 1 | APB direction |
| paddr_o | output | AW | APB address |
| pwdata_o | output | DW | APB write data |
| pstrb_o | output | DW/8 | APB write strobes |
| prdata_i | input | DW | APB read data |
| pready_i | input | 1 | APB ready |
| pslverr_i | input | 1 | APB slave error |
| busy_o | output | 1 | A posted write is pending |
| post_err_o | output | 1 | Sticky error from a posted write |

## Verification
The assertions rely on the master being the only one on the bus. It drives either IDLE or NONSEQ, and it holds `hwdata_i` and `hwstrb_i` steady for the whole data phase. They also assume the peripheral raises `pslverr_i` only together with `pready_i`. The bench master waits for each response before presenting the next address, and it keeps the data-phase signals unchanged until then. Its peripheral model derives `pready_i` from a count of access cycles and ties the error to `pready_i` in a fixed address window.

// File: rtl/apb_post_pkg.sv
package apb_post_pkg;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_SETUP, SEQ_ACCESS, SEQ_DONE} seq_state_e;
  typedef enum logic [1:0] {PH_NONE, PH_DATA, PH_ERR} ahb_phase_e;
endpackage

// File: rtl/apb_tick_gen.sv
module apb_tick_gen #(
  parameter int DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             idle_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] div_q, cnt_q, div_eff;

  assign div_eff = (div_i == '0) ? DIV_W'(1) : div_i;
  assign tick_o  = (cnt_q == div_q - DIV_W'(1));

  // ratio only reloads while nothing is in flight
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= DIV_W'(1);
      cnt_q <= '0;
    end else if (idle_i) begin
      div_q <= div_eff;
      cnt_q <= '0;
    end else if (tick_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/post_buf.sv
module post_buf #(
  parameter int AW = 16,
  parameter int DW = 32,
  localparam int SW = DW / 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          pop_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic [SW-1:0] strb_i,
  output logic          valid_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic [SW-1:0] strb_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      data_o  <= '0;
      strb_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      addr_o  <= addr_i;
      data_o  <= data_i;
      strb_o  <= strb_i;
    end else if (pop_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/apb_seq.sv
module apb_seq import apb_post_pkg::*; #(
  parameter int AW = 16,
  parameter int DW = 32,
  localparam int SW = DW / 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          req_i,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_data_i,
  input  logic [SW-1:0] req_strb_i,
  output logic          start_o,
  output logic          idle_o,
  output logic          done_o,
  output logic          err_o,
  output logic [DW-1:0] rdata_o,
  output logic          psel_o,
  output logic          penable_o,
  output logic          pwrite_o,
  output logic [AW-1:0] paddr_o,
  output logic [DW-1:0] pwdata_o,
  output logic [SW-1:0] pstrb_o,
  input  logic [DW-1:0] prdata_i,
  input  logic          pready_i,
  input  logic          pslverr_i
);
  seq_state_e state_q;

  assign idle_o    = (state_q == SEQ_IDLE);
  assign done_o    = (state_q == SEQ_DONE);
  assign start_o   = idle_o && tick_i && req_i;
  assign psel_o    = (state_q == SEQ_SETUP) || (state_q == SEQ_ACCESS);
  assign penable_o = (state_q == SEQ_ACCESS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= SEQ_IDLE;
      pwrite_o <= 1'b0;
      paddr_o  <= '0;
      pwdata_o <= '0;
      pstrb_o  <= '0;
      rdata_o  <= '0;
      err_o    <= 1'b0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: if (start_o) begin
          state_q  <= SEQ_SETUP;
          pwrite_o <= req_write_i;
          paddr_o  <= req_addr_i;
          pwdata_o <= req_data_i;
          pstrb_o  <= req_strb_i;
        end
        SEQ_SETUP: if (tick_i) state_q <= SEQ_ACCESS;
        SEQ_ACCESS: if (tick_i && pready_i) begin
          state_q <= SEQ_DONE;
          rdata_o <= prdata_i;
          err_o   <= pslverr_i;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ahb_apb_post_bridge.sv
module ahb_apb_post_bridge import apb_post_pkg::*; #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DIV_W = 4,
  localparam int SW   = DW / 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             hsel_i,
  input  logic [1:0]       htrans_i,
  input  logic             hwrite_i,
  input  logic             hprot_buf_i,
  input  logic [AW-1:0]    haddr_i,
  input  logic [SW-1:0]    hwstrb_i,
  input  logic [DW-1:0]    hwdata_i,
  output logic [DW-1:0]    hrdata_o,
  output logic             hready_o,
  output logic             hresp_o,
  output logic             psel_o,
  output logic             penable_o,
  output logic             pwrite_o,
  output logic [AW-1:0]    paddr_o,
  output logic [DW-1:0]    pwdata_o,
  output logic [SW-1:0]    pstrb_o,
  input  logic [DW-1:0]    prdata_i,
  input  logic             pready_i,
  input  logic             pslverr_i,
  output logic             busy_o,
  output logic             post_err_o
);
  ahb_phase_e    phase_q;
  logic [AW-1:0] cur_addr_q;
  logic          cur_write_q, cur_buf_q, issued_q;
  logic          buf_valid, buf_load, buf_pop;
  logic [AW-1:0] buf_addr;
  logic [DW-1:0] buf_data;
  logic [SW-1:0] buf_strb;
  logic          tick, seq_idle, seq_start, seq_done, seq_err;
  logic          cur_post, direct_req, seq_req, accept, bridge_idle;
  logic          req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_data;
  logic [SW-1:0] req_strb;
  logic          unused_trans0;

  assign unused_trans0 = htrans_i[0];
  assign cur_post      = cur_write_q && cur_buf_q;
  assign accept        = hsel_i && htrans_i[1] && hready_o;
  assign bridge_idle   = !buf_valid && seq_idle && (phase_q == PH_NONE);
  assign direct_req    = (phase_q == PH_DATA) && !cur_post && !buf_valid && !issued_q;
  assign buf_load      = (phase_q == PH_DATA) && cur_post && !buf_valid;
  assign buf_pop       = seq_done && buf_valid;
  assign seq_req       = buf_valid || direct_req;
  assign busy_o        = buf_valid;

  // posted entry always goes first: that is what orders reads behind it
  always_comb begin
    if (buf_valid) begin
      req_write = 1'b1;
      req_addr  = buf_addr;
      req_data  = buf_data;
      req_strb  = buf_strb;
    end else begin
      req_write = cur_write_q;
      req_addr  = cur_addr_q;
      req_data  = hwdata_i;
      req_strb  = cur_write_q ? hwstrb_i : '0;
    end
  end

  always_comb begin
    hready_o = 1'b1;
    hresp_o  = 1'b0;
    unique case (phase_q)
      PH_ERR: hresp_o = 1'b1;
      PH_DATA: begin
        if (cur_post) begin
          hready_o = !buf_valid;
        end else begin
          hready_o = issued_q && seq_done && !seq_err;
          hresp_o  = issued_q && seq_done && seq_err;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= PH_NONE;
      cur_addr_q  <= '0;
      cur_write_q <= 1'b0;
      cur_buf_q   <= 1'b0;
      issued_q    <= 1'b0;
      post_err_o  <= 1'b0;
    end else begin
      if (phase_q == PH_DATA && !cur_post && issued_q && seq_done && seq_err)
        phase_q <= PH_ERR;
      else if (hready_o)
        phase_q <= accept ? PH_DATA : PH_NONE;
      if (accept) begin
        cur_addr_q  <= haddr_i;
        cur_write_q <= hwrite_i;
        cur_buf_q   <= hprot_buf_i;
      end
      if (seq_start && !buf_valid) issued_q <= 1'b1;
      else if (seq_done)           issued_q <= 1'b0;
      if (buf_pop && seq_err) post_err_o <= 1'b1;
    end
  end

  apb_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk_i (clk_i), .rst_ni(rst_ni), .idle_i(bridge_idle), .div_i(div_i), .tick_o(tick)
  );

  post_buf #(.AW(AW), .DW(DW)) u_buf (
    .clk_i  (clk_i),    .rst_ni (rst_ni),
    .load_i (buf_load), .pop_i  (buf_pop),
    .addr_i (cur_addr_q), .data_i (hwdata_i), .strb_i (hwstrb_i),
    .valid_o(buf_valid), .addr_o (buf_addr), .data_o (buf_data), .strb_o (buf_strb)
  );

  apb_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk_i      (clk_i),     .rst_ni     (rst_ni),    .tick_i    (tick),
    .req_i      (seq_req),   .req_write_i(req_write), .req_addr_i(req_addr),
    .req_data_i (req_data),  .req_strb_i (req_strb),
    .start_o    (seq_start), .idle_o     (seq_idle),  .done_o    (seq_done),
    .err_o      (seq_err),   .rdata_o    (hrdata_o),
    .psel_o     (psel_o),    .penable_o  (penable_o), .pwrite_o  (pwrite_o),
    .paddr_o    (paddr_o),   .pwdata_o   (pwdata_o),  .pstrb_o   (pstrb_o),
    .prdata_i   (prdata_i),  .pready_i   (pready_i),  .pslverr_i (pslverr_i)
  );
endmodule

// File: rtl/ahb_apb_post_bridge_chk.sv
module ahb_apb_post_bridge_chk #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          hsel_i,
  input logic [1:0]    htrans_i,
  input logic          hwrite_i,
  input logic          hready_o,
  input logic          hresp_o,
  input logic          psel_o,
  input logic          penable_o,
  input logic [AW-1:0] paddr_o,
  input logic [DW-1:0] pwdata_o,
  input logic          pready_i,
  input logic          busy_o,
  input logic          post_err_o
);
  logic rd_pend_q, rd_accept;

  assign rd_accept = hsel_i && htrans_i[1] && !hwrite_i && hready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 rd_pend_q <= 1'b0;
    else if (rd_pend_q && hready_o) rd_pend_q <= rd_accept;
    else if (rd_accept)          rd_pend_q <= 1'b1;
  end

  p_enable_in_sel_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    penable_o |-> psel_o);
  p_setup_first_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(penable_o) |-> $past(psel_o && !penable_o));
  p_access_held_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (penable_o && !pready_i) |=> penable_o);
  p_payload_stable_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    penable_o |-> ($stable(paddr_o) && $stable(pwdata_o)));
  p_read_after_drain_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_pend_q && hready_o && !hresp_o) |-> !busy_o);
  p_err_two_cycle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hresp_o && !hready_o) |=> (hresp_o && hready_o));
  p_sticky_err_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    post_err_o |=> post_err_o);
endmodule

bind ahb_apb_post_bridge ahb_apb_post_bridge_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/ahb_apb_post_bridge_test.sv
`timescale 1ns/1ps
module ahb_apb_post_bridge_test;
  localparam int AW = 16, DW = 32, SW = 4, DIV_W = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [DIV_W-1:0] div_i = 4'd4;
  logic hsel = 0, hwrite = 0, hprot_buf = 0;
  logic [1:0] htrans = 2'b00;
  logic [AW-1:0] haddr = '0;
  logic [SW-1:0] hwstrb = '0;
  logic [DW-1:0] hwdata = '0;
  logic [DW-1:0] hrdata_o, pwdata_o, prdata_i;
  logic hready_o, hresp_o, psel_o, penable_o, pwrite_o, pready_i, pslverr_i, busy_o, post_err_o;
  logic [AW-1:0] paddr_o;
  logic [SW-1:0] pstrb_o;

  int n_vec = 0, n_bad = 0;
  int slave_wait = 0, acc_cnt = 0;

  always #10 clk = ~clk;

  ahb_apb_post_bridge #(.AW(AW), .DW(DW), .DIV_W(DIV_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .div_i(div_i), .hsel_i(hsel), .htrans_i(htrans),
    .hwrite_i(hwrite), .hprot_buf_i(hprot_buf), .haddr_i(haddr), .hwstrb_i(hwstrb),
    .hwdata_i(hwdata), .hrdata_o(hrdata_o), .hready_o(hready_o), .hresp_o(hresp_o),
    .psel_o(psel_o), .penable_o(penable_o), .pwrite_o(pwrite_o), .paddr_o(paddr_o),
    .pwdata_o(pwdata_o), .pstrb_o(pstrb_o), .prdata_i(prdata_i), .pready_i(pready_i),
    .pslverr_i(pslverr_i), .busy_o(busy_o), .post_err_o(post_err_o));

  // peripheral: wait counted in access cycles, error window at 0xExxx
  always @(posedge clk) acc_cnt <= penable_o ? acc_cnt + 1 : 0;
  assign pready_i  = penable_o && (acc_cnt >= slave_wait);
  assign pslverr_i = pready_i && (paddr_o[15:12] == 4'hE);
  assign prdata_i  = {paddr_o, 16'h5A5A};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // APB transfer log, one entry per SETUP entry
  logic [AW-1:0] lg_addr[$];
  logic lg_w; logic [SW-1:0] lg_s;
  logic prev_psel = 0;
  always @(negedge clk) begin
    if (psel_o && !prev_psel) begin lg_addr.push_back(paddr_o); lg_w = pwrite_o; lg_s = pstrb_o; end
    prev_psel = psel_o;
  end

  // behavioural reference model, evaluated mid-cycle
  int m_phase, m_seq, m_cnt, m_div;
  bit m_cwr, m_cbuf, m_issued, m_derr, m_sticky, m_pw;
  logic [AW-1:0] m_caddr, m_pa;
  logic [DW-1:0] m_ddata, m_pd;
  logic [SW-1:0] m_ps;
  logic [AW-1:0] q_a[$];
  logic [DW-1:0] q_d[$];
  logic [SW-1:0] q_s[$];

  always @(negedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_seq = 0; m_cnt = 0; m_div = 1; m_cwr = 0; m_cbuf = 0; m_issued = 0;
      m_derr = 0; m_sticky = 0; m_pw = 0; m_caddr = '0; m_pa = '0; m_ddata = '0; m_pd = '0; m_ps = '0;
      q_a.delete(); q_d.delete(); q_s.delete();
    end else begin
      bit o_empty, cpost, e_hready, e_hresp, fin, tick, idle, acc, dreq;
      int o_seq; bit o_issued, o_derr;
      o_empty = (q_a.size() == 0); o_seq = m_seq; o_issued = m_issued; o_derr = m_derr;
      cpost = m_cwr && m_cbuf;
      e_hready = 1; e_hresp = 0; fin = 0;
      if (m_phase == 2) e_hresp = 1;
      else if (m_phase == 1) begin
        if (cpost) e_hready = o_empty;
        else begin
          e_hready = 0;
          if (o_issued && o_seq == 3) begin fin = 1; e_hready = !o_derr; e_hresp = o_derr; end
        end
      end
      chk(hready_o === e_hready, "R3 hready", 32'(hready_o), 32'(e_hready));
      chk(hresp_o === e_hresp, "R8 hresp", 32'(hresp_o), 32'(e_hresp));
      chk(busy_o === !o_empty, "R2 busy", 32'(busy_o), 32'(!o_empty));
      chk(psel_o === (o_seq == 1 || o_seq == 2), "R6 psel", 32'(psel_o), 32'(o_seq == 1 || o_seq == 2));
      chk(penable_o === (o_seq == 2), "R6 penable", 32'(penable_o), 32'(o_seq == 2));
      chk(post_err_o === m_sticky, "R9 post_err", 32'(post_err_o), 32'(m_sticky));
      if (fin && !m_cwr && !o_derr) chk(hrdata_o === m_ddata, "R4 hrdata", hrdata_o, m_ddata);
      if (o_seq == 1 || o_seq == 2) begin
        chk(paddr_o === m_pa, "R11 paddr", 32'(paddr_o), 32'(m_pa));
        chk(pwrite_o === m_pw, "R11 pwrite", 32'(pwrite_o), 32'(m_pw));
        chk(pstrb_o === m_ps, "R11 pstrb", 32'(pstrb_o), 32'(m_ps));
        if (m_pw) chk(pwdata_o === m_pd, "R11 pwdata", pwdata_o, m_pd);
      end
      tick = (m_cnt == m_div - 1);
      idle = o_empty && o_seq == 0 && m_phase == 0;
      acc  = hsel && htrans[1] && e_hready;
      dreq = (m_phase == 1) && !cpost && o_empty && !o_issued;
      // AHB side
      if (m_phase == 1 && cpost) begin
        if (o_empty) begin
          q_a.push_back(m_caddr); q_d.push_back(hwdata); q_s.push_back(hwstrb);
          m_phase = acc ? 1 : 0;
        end
      end else if (m_phase == 1) begin
        if (fin) begin m_issued = 0; m_phase = o_derr ? 2 : (acc ? 1 : 0); end
      end else m_phase = acc ? 1 : 0;
      if (acc) begin m_caddr = haddr; m_cwr = hwrite; m_cbuf = hprot_buf; end
      // APB side
      case (o_seq)
        0: if (tick && (!o_empty || dreq)) begin
             m_seq = 1;
             if (!o_empty) begin m_pa = q_a[0]; m_pd = q_d[0]; m_ps = q_s[0]; m_pw = 1; end
             else begin
               m_pa = m_caddr; m_pw = m_cwr; m_pd = hwdata; m_ps = m_cwr ? hwstrb : '0; m_issued = 1;
             end
           end
        1: if (tick) m_seq = 2;
        2: if (tick && pready_i) begin m_seq = 3; m_derr = pslverr_i; m_ddata = prdata_i; end
        default: begin
          m_seq = 0;
          if (!o_empty) begin
            m_sticky = m_sticky | o_derr;
            void'(q_a.pop_front()); void'(q_d.pop_front()); void'(q_s.pop_front());
          end
        end
      endcase
      if (idle) begin m_cnt = 0; m_div = (div_i == 0) ? 1 : int'(div_i); end
      else m_cnt = tick ? 0 : m_cnt + 1;
    end
  end

  task automatic xfer(input bit wr, input bit bufb, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic [SW-1:0] s, output int cyc, output bit err, output logic [DW-1:0] rd);
    @(posedge clk); #1;
    hsel = 1; htrans = 2'b10; hwrite = wr; hprot_buf = bufb; haddr = a;
    do @(negedge clk); while (!hready_o);
    @(posedge clk); #1;
    hsel = 0; htrans = 2'b00; hwdata = d; hwstrb = wr ? s : '0;
    cyc = 0; err = 0; rd = '0;
    forever begin
      @(negedge clk);
      cyc++;
      if (hresp_o) err = 1;
      if (hready_o) begin rd = hrdata_o; break; end
    end
  endtask

  task automatic quiet();
    do @(negedge clk); while (busy_o || psel_o);
    repeat (4) @(negedge clk);
  endtask

  task automatic busy_len(output int n);
    n = 0;
    forever begin
      @(negedge clk);
      if (busy_o) n++; else break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int c, n; bit e; logic [DW-1:0] r;
    repeat (3) @(posedge clk); #1; rst_n = 1;
    @(negedge clk);
    chk(hready_o && !hresp_o && !psel_o && !penable_o && !busy_o && !post_err_o, "R1 reset",
        {hready_o, hresp_o, psel_o, penable_o, busy_o, post_err_o}, 32'h20);
    repeat (3) @(negedge clk);
    // R2, R7: posted write at N=4
    xfer(1, 1, 16'h0100, 32'hA1, 4'hF, c, e, r);
    chk(c == 1 && !e, "R2 zero-wait posted", c, 1);
    busy_len(n);
    chk(n == 12, "R7 drain N=4", n, 12);
    quiet();
    // R10: ratio change while busy is ignored
    xfer(1, 1, 16'h0104, 32'hA2, 4'h3, c, e, r);
    div_i = 4'd8;
    busy_len(n);
    chk(n == 12, "R10 ratio held", n, 12);
    quiet();
    xfer(1, 1, 16'h0108, 32'hA3, 4'hF, c, e, r);
    busy_len(n);
    chk(n == 24, "R7 drain N=8", n, 24);
    div_i = 4'd4; quiet();
    // R3, R11: non-posted write
    xfer(1, 0, 16'h0200, 32'hB1, 4'b0110, c, e, r);
    chk(c == 13 && !e, "R3 nonposted latency", c, 13);
    chk(lg_addr[$] == 16'h0200 && lg_w && lg_s == 4'b0110, "R11 write payload", {lg_addr[$], 11'd0, lg_w, lg_s}, {16'h0200, 11'd0, 1'b1, 4'b0110});
    quiet();
    // R6: slow peripheral extends ACCESS by one tick
    slave_wait = 5;
    xfer(0, 0, 16'h0300, 32'h0, 4'h0, c, e, r);
    chk(c == 17, "R6 access extended", c, 17);
    chk(r == 32'h03005A5A, "R6 read data", r, 32'h03005A5A);
    chk(!lg_w && lg_s == 4'h0, "R11 read strobes", {lg_w, lg_s}, 0);
    slave_wait = 0; quiet();
    // R4: read behind posted write
    xfer(1, 1, 16'h0400, 32'hC1, 4'hF, c, e, r);
    xfer(0, 0, 16'h0404, 32'h0, 4'h0, c, e, r);
    chk(r == 32'h04045A5A, "R4 read data", r, 32'h04045A5A);
    chk(lg_addr[$-1] == 16'h0400 && lg_addr[$] == 16'h0404, "R4 order", {lg_addr[$-1], lg_addr[$]}, 32'h04000404);
    chk(c > 13, "R4 read waited", c, 14);
    quiet();
    // R5: second posted write stalls on full store
    xfer(1, 1, 16'h0500, 32'hD1, 4'hF, c, e, r);
    xfer(1, 1, 16'h0504, 32'hD2, 4'hF, c, e, r);
    chk(c > 1 && !e, "R5 stall when full", c, 2);
    quiet();
    chk(lg_addr[$-1] == 16'h0500 && lg_addr[$] == 16'h0504, "R5 order", {lg_addr[$-1], lg_addr[$]}, 32'h05000504);
    // R8: slave error on non-posted transfers
    xfer(1, 0, 16'hE000, 32'hE1, 4'hF, c, e, r);
    chk(e, "R8 write error", e, 1);
    quiet();
    xfer(0, 0, 16'hE010, 32'h0, 4'h0, c, e, r);
    chk(e, "R8 read error", e, 1);
    quiet();
    chk(!post_err_o, "R9 no sticky yet", post_err_o, 0);
    // R9: posted write error goes sticky
    xfer(1, 1, 16'hE004, 32'hE2, 4'hF, c, e, r);
    chk(c == 1 && !e, "R9 posted ok resp", {c[30:0], e}, 2);
    quiet();
    chk(post_err_o, "R9 sticky set", post_err_o, 1);
    xfer(1, 1, 16'h0600, 32'hF1, 4'hF, c, e, r);
    quiet();
    chk(post_err_o, "R9 sticky held", post_err_o, 1);
    // R7: ratio 0 behaves as 1
    div_i = 4'd0; quiet();
    xfer(0, 0, 16'h0700, 32'h0, 4'h0, c, e, r);
    chk(c == 4, "R7 ratio zero", c, 4);
    quiet();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule